// File: doc/BRIEF.md
# System Bus Clock Divider Chain

This block derives four fixed-ratio clocks from a core clock. The first stage divides the core clock by 2, 3 or 4 to make the system bus clock. A peripheral clock runs at half the bus rate. A memory clock runs at either the full or the half bus rate. A static-bus clock for synchronous external devices is a divided copy of the peripheral clock. Every ratio comes from a small configuration field. A mode strap chooses between two encodings of the static-bus ratio: a one-bit legacy encoding and a wider three-bit encoding.

All four outputs are registered levels in the core clock domain, so there is one clock tree and no derived-clock flops. Each divider stage moves forward only on the cycle in which its parent output rises. That cycle is marked by a one-cycle rise pulse that the parent stage produces. Each stage is a small state machine with four states:
- `ST_RESET`: output low, waiting for the first parent edge.
- `ST_HIGH`: output high.
- `ST_LOW`: output low.
- `ST_PASS`: a ratio of one, where the output follows the parent level.

The stage has these transitions:
- Start of period: from `ST_RESET`, or from `ST_LOW` once the full ratio has been counted, or from `ST_PASS`, on a parent edge. The stage latches the new ratio and enters `ST_HIGH`, or `ST_PASS` if the ratio is one.
- High to low: from `ST_HIGH` to `ST_LOW`, once the high phase has been counted.

Top module: `sysclk_div_chain`

## Requirements
- R1: For `bus_div_sel` values 0, 1 and 2, `bus_clk` has a period of (`bus_div_sel`+2) core cycles and is high for ceil(ratio/2) of them.
- R2: `bus_div_sel` value 3 is reserved and gives divide-by-4, the same as value 2.
- R3: `per_clk` has a period of two `bus_clk` periods and is high for exactly one `bus_clk` period.
- R4: `mem_clk` equals `bus_clk` when bit `MEM_FULL_BIT` of `mem_cfg` is 1, and is `bus_clk` divided by 2 when that bit is 0. All other `mem_cfg` bits have no effect.
- R5: With `legacy_mode`=1, `sb_clk` is `per_clk` divided by 4 when `sbus_cfg[11]` is 0, and divided by 5 when it is 1. `sbus_cfg[15:13]` is ignored.
- R6: With `legacy_mode`=0, `sb_clk` is `per_clk` divided by (`sbus_cfg[15:13]`+1), which is 1 to 8. A ratio of one reproduces `per_clk`. `sbus_cfg[11]` is ignored.
- R7: For an odd ratio N, the high phase lasts (N+1)/2 parent periods and the low phase lasts (N-1)/2.
- R8: `rst` is synchronous. In the cycle after any clock edge that samples `rst` high, all four outputs are low.
- R9: A change to a stage's ratio takes effect only at the start of that stage's next full output period. The period in progress finishes with the old ratio.
- R10: Every transition of a divided output comes one core cycle after a rising edge of its parent clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| legacy_mode | input | 1 | Strap: 1 selects the one-bit static-bus encoding |
| bus_div_sel | input | 2 | Bus divider field, ratio = field+2 |
| mem_cfg | input | MEM_CFG_W | Memory configuration word holding the full-rate bit |
| sbus_cfg | input | 16 | Static-bus configuration word (bit 11, bits 15:13) |
| bus_clk | output | 1 | System bus clock |
| per_clk | output | 1 | Peripheral clock |
| mem_clk | output | 1 | Memory clock |
| sb_clk | output | 1 | Static-bus clock |

## Verification
The bench builds the block with `MEM_FULL_BIT`=31. It drives bit 15 high whenever bit 31 is low, which shows that a memory-bit position other than the configured one is ignored.

The bench sweeps every bus field value, including the reserved one. For each, it runs both legacy settings with the wider field's bits held at zero, and all eight new-mode ratios with bit 11 set. It runs each of these with both memory settings, and measures the period and high time of every output.

A separate run changes the static ratio in the middle of a long period. It checks that the old period completes before the new ratio applies.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    typedef enum logic [1:0] {
        ST_RESET = 2'd0,
        ST_HIGH  = 2'd1,
        ST_LOW   = 2'd2,
        ST_PASS  = 2'd3
    } div_state_t;

    // Static-bus word: positions decoded by the attached controller
    localparam int SB_LEGACY_BIT = 11;
    localparam int SB_FIELD_LSB  = 13;
    localparam int SB_FIELD_W    = 3;
    localparam int SB_CFG_W      = 16;

endpackage

// File: rtl/clkdiv_ratio_dec.sv
module clkdiv_ratio_dec #(
    parameter int BUS_SEL_W    = 2,
    parameter int MEM_CFG_W    = 32,
    parameter int MEM_FULL_BIT = 15,
    parameter int RATIO_W      = 4
) (
    input  logic                           legacy_mode,
    input  logic [BUS_SEL_W-1:0]           bus_div_sel,
    input  logic [MEM_CFG_W-1:0]           mem_cfg,
    input  logic [clkdiv_pkg::SB_CFG_W-1:0] sbus_cfg,
    output logic [RATIO_W-1:0]             bus_ratio,
    output logic [RATIO_W-1:0]             mem_ratio,
    output logic [RATIO_W-1:0]             sb_ratio
);
    import clkdiv_pkg::*;

    localparam logic [BUS_SEL_W-1:0] BUS_RESERVED = '1;
    localparam logic [RATIO_W-1:0]   BUS_MAX_RATIO = RATIO_W'(4);

    logic [SB_FIELD_W-1:0] sb_field;

    assign sb_field = sbus_cfg[SB_FIELD_LSB +: SB_FIELD_W];

    always_comb begin
        if (bus_div_sel == BUS_RESERVED) begin
            bus_ratio = BUS_MAX_RATIO;
        end else begin
            bus_ratio = RATIO_W'(bus_div_sel) + RATIO_W'(2);
        end
    end

    assign mem_ratio = mem_cfg[MEM_FULL_BIT] ? RATIO_W'(1) : RATIO_W'(2);

    always_comb begin
        if (legacy_mode) begin
            sb_ratio = sbus_cfg[SB_LEGACY_BIT] ? RATIO_W'(5) : RATIO_W'(4);
        end else begin
            sb_ratio = RATIO_W'(sb_field) + RATIO_W'(1);
        end
    end

endmodule

// File: rtl/clkdiv_stage.sv
module clkdiv_stage #(
    parameter int RATIO_W = 4
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               adv,
    input  logic               parent_lvl,
    input  logic [RATIO_W-1:0] ratio_in,
    output logic               clk_out,
    output logic               rise_out
);
    import clkdiv_pkg::*;

    div_state_t         st_q, st_d;
    logic [RATIO_W-1:0] cnt_q, cnt_d;
    logic [RATIO_W-1:0] ratio_q, ratio_d;
    logic               rise_q, rise_d;
    logic [RATIO_W-1:0] hi_len;
    logic               period_start;

    assign hi_len = (ratio_q + RATIO_W'(1)) >> 1;

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_RESET;
            cnt_q   <= '0;
            ratio_q <= '0;
            rise_q  <= 1'b0;
        end else begin
            st_q    <= st_d;
            cnt_q   <= cnt_d;
            ratio_q <= ratio_d;
            rise_q  <= rise_d;
        end
    end

    // next state
    always_comb begin
        st_d         = st_q;
        cnt_d        = cnt_q;
        ratio_d      = ratio_q;
        rise_d       = 1'b0;
        period_start = 1'b0;
        unique case (st_q)
            ST_RESET: begin
                if (adv) period_start = 1'b1;
            end
            ST_HIGH: begin
                if (adv) begin
                    if (cnt_q == hi_len) st_d = ST_LOW;
                    cnt_d = cnt_q + RATIO_W'(1);
                end
            end
            ST_LOW: begin
                if (adv) begin
                    if (cnt_q == ratio_q) period_start = 1'b1;
                    else cnt_d = cnt_q + RATIO_W'(1);
                end
            end
            ST_PASS: begin
                if (adv) period_start = 1'b1;
            end
        endcase
        if (period_start) begin
            ratio_d = ratio_in;
            cnt_d   = RATIO_W'(1);
            if (ratio_in <= RATIO_W'(1)) begin
                st_d = ST_PASS;
            end else begin
                st_d   = ST_HIGH;
                rise_d = 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        unique case (st_q)
            ST_RESET: begin clk_out = 1'b0;       rise_out = 1'b0;   end
            ST_HIGH:  begin clk_out = 1'b1;       rise_out = rise_q; end
            ST_LOW:   begin clk_out = 1'b0;       rise_out = 1'b0;   end
            ST_PASS:  begin clk_out = parent_lvl; rise_out = adv;    end
        endcase
    end

endmodule

// File: rtl/sysclk_div_chain.sv
module sysclk_div_chain #(
    parameter int BUS_SEL_W    = 2,
    parameter int MEM_CFG_W    = 32,
    parameter int MEM_FULL_BIT = 15
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 legacy_mode,
    input  logic [BUS_SEL_W-1:0] bus_div_sel,
    input  logic [MEM_CFG_W-1:0] mem_cfg,
    input  logic [15:0]          sbus_cfg,
    output logic                 bus_clk,
    output logic                 per_clk,
    output logic                 mem_clk,
    output logic                 sb_clk
);
    import clkdiv_pkg::*;

    localparam int SB_MAX_RATIO  = 2 ** SB_FIELD_W;
    localparam int BUS_MAX_RATIO = 2 ** BUS_SEL_W;
    localparam int MAX_RATIO     = (SB_MAX_RATIO > BUS_MAX_RATIO) ? SB_MAX_RATIO : BUS_MAX_RATIO;
    localparam int RATIO_W       = $clog2(MAX_RATIO + 2);
    localparam int NUM_STAGES    = 4;
    localparam int IDX_BUS = 0, IDX_PER = 1, IDX_MEM = 2, IDX_SB = 3;

    logic [RATIO_W-1:0] bus_ratio, mem_ratio, sb_ratio;
    logic [RATIO_W-1:0] stage_ratio [NUM_STAGES];
    logic [NUM_STAGES-1:0] stage_adv, stage_parent, stage_clk, stage_rise;

    clkdiv_ratio_dec #(
        .BUS_SEL_W   (BUS_SEL_W),
        .MEM_CFG_W   (MEM_CFG_W),
        .MEM_FULL_BIT(MEM_FULL_BIT),
        .RATIO_W     (RATIO_W)
    ) u_dec (
        .legacy_mode(legacy_mode),
        .bus_div_sel(bus_div_sel),
        .mem_cfg    (mem_cfg),
        .sbus_cfg   (sbus_cfg),
        .bus_ratio  (bus_ratio),
        .mem_ratio  (mem_ratio),
        .sb_ratio   (sb_ratio)
    );

    // Chain topology: core -> bus -> {per, mem}; per -> static bus
    assign stage_ratio[IDX_BUS] = bus_ratio;
    assign stage_ratio[IDX_PER] = RATIO_W'(2);
    assign stage_ratio[IDX_MEM] = mem_ratio;
    assign stage_ratio[IDX_SB]  = sb_ratio;

    assign stage_adv[IDX_BUS]    = 1'b1;
    assign stage_parent[IDX_BUS] = 1'b1;
    assign stage_adv[IDX_PER]    = stage_rise[IDX_BUS];
    assign stage_parent[IDX_PER] = stage_clk[IDX_BUS];
    assign stage_adv[IDX_MEM]    = stage_rise[IDX_BUS];
    assign stage_parent[IDX_MEM] = stage_clk[IDX_BUS];
    assign stage_adv[IDX_SB]     = stage_rise[IDX_PER];
    assign stage_parent[IDX_SB]  = stage_clk[IDX_PER];

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        clkdiv_stage #(.RATIO_W(RATIO_W)) u_stage (
            .clk       (clk),
            .rst       (rst),
            .adv       (stage_adv[g]),
            .parent_lvl(stage_parent[g]),
            .ratio_in  (stage_ratio[g]),
            .clk_out   (stage_clk[g]),
            .rise_out  (stage_rise[g])
        );
    end

    assign bus_clk = stage_clk[IDX_BUS];
    assign per_clk = stage_clk[IDX_PER];
    assign mem_clk = stage_clk[IDX_MEM];
    assign sb_clk  = stage_clk[IDX_SB];

endmodule

// File: rtl/sysclk_div_chain_chk.sv
module sysclk_div_chain_chk (
    input logic clk,
    input logic rst,
    input logic bus_clk,
    input logic per_clk,
    input logic mem_clk,
    input logic sb_clk
);

    AST_RESET_LOW: assert property (@(posedge clk)
        rst |=> (!bus_clk && !per_clk && !mem_clk && !sb_clk)); // R8

    AST_BUS_HIGH_MAX: assert property (@(posedge clk) disable iff (rst)
        (bus_clk && $past(bus_clk)) |=> !bus_clk); // R1

    AST_BUS_LOW_MAX: assert property (@(posedge clk) disable iff (rst)
        (!bus_clk && !$past(bus_clk)) |=> bus_clk); // R7

    AST_PER_FOLLOWS_BUS: assert property (@(posedge clk) disable iff (rst)
        (per_clk != $past(per_clk)) |-> ($past(bus_clk) && !$past(bus_clk, 2))); // R3

    AST_MEM_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(mem_clk) |-> (bus_clk || $past(bus_clk))); // R4

    AST_SB_RISE: assert property (@(posedge clk) disable iff (rst)
        $rose(sb_clk) |-> (per_clk || $past(per_clk))); // R10

endmodule

bind sysclk_div_chain sysclk_div_chain_chk u_chk (
    .clk    (clk),
    .rst    (rst),
    .bus_clk(bus_clk),
    .per_clk(per_clk),
    .mem_clk(mem_clk),
    .sb_clk (sb_clk)
);

// File: tb/sysclk_div_chain_test.sv
module sysclk_div_chain_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        legacy_mode = 1'b0;
    logic [1:0]  bus_div_sel = 2'd0;
    logic [31:0] mem_cfg = 32'd0;
    logic [15:0] sbus_cfg = 16'd0;
    logic        bus_clk, per_clk, mem_clk, sb_clk;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;

    always #10 clk = ~clk;

    sysclk_div_chain #(.MEM_FULL_BIT(31)) uut (
        .clk        (clk),
        .rst        (rst),
        .legacy_mode(legacy_mode),
        .bus_div_sel(bus_div_sel),
        .mem_cfg    (mem_cfg),
        .sbus_cfg   (sbus_cfg),
        .bus_clk    (bus_clk),
        .per_clk    (per_clk),
        .mem_clk    (mem_clk),
        .sb_clk     (sb_clk)
    );

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles, expected under 150000", cycles);
            finish_run();
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic sig(input int s);
        case (s)
            0: return bus_clk;
            1: return per_clk;
            2: return mem_clk;
            default: return sb_clk;
        endcase
    endfunction

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Locate a rising edge, then measure high time and period in core cycles
    task automatic measure(input int s, output int per, output int hi);
        logic p, c, low_seen, done;
        int guard;
        @(negedge clk);
        p = sig(s);
        guard = 0;
        done = 1'b0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            c = sig(s);
            done = !p && c;
            p = c;
            guard++;
        end
        per = 0;
        hi = 1;
        low_seen = 1'b0;
        done = 1'b0;
        guard = 0;
        while (!done && guard < 1000) begin
            @(negedge clk);
            c = sig(s);
            per++;
            guard++;
            if (!c) low_seen = 1'b1;
            else if (!low_seen) hi++;
            else done = 1'b1;
        end
    endtask

    initial begin
        int p, h, br, sr, sb_per, sb_hi;
        string tag;

        // R8: outputs held low by reset
        wait_cycles(5);
        check("R8 bus in reset", int'(bus_clk), 0);
        check("R8 per in reset", int'(per_clk), 0);
        check("R8 mem in reset", int'(mem_clk), 0);
        check("R8 sb in reset", int'(sb_clk), 0);
        rst = 1'b0;
        @(negedge clk);
        check("R8 sb after release", int'(sb_clk), 0);
        check("R8 per after release", int'(per_clk), 0);

        for (int bf = 0; bf < 4; bf++) begin
            for (int md = 0; md < 10; md++) begin
                for (int mb = 0; mb < 2; mb++) begin
                    bus_div_sel = 2'(bf);
                    // bit 15 is a decoy: only bit 31 is configured
                    mem_cfg = (mb != 0) ? 32'h8000_0000 : 32'h0000_8000;
                    if (md < 2) begin
                        legacy_mode = 1'b1;
                        sbus_cfg = 16'(md << 11);
                        sr = (md == 1) ? 5 : 4;
                    end else begin
                        legacy_mode = 1'b0;
                        sbus_cfg = 16'(((md - 2) << 13) | (1 << 11));
                        sr = md - 1;
                    end
                    br = (bf == 3) ? 4 : bf + 2;
                    wait_cycles(300);

                    tag = (bf == 3) ? "R2 bus" : "R1 bus";
                    measure(0, p, h);
                    check({tag, " period"}, p, br);
                    check({tag, " high R7"}, h, (br + 1) / 2);

                    measure(1, p, h);
                    check("R3 per period", p, 2 * br);
                    check("R3 per high", h, br);

                    measure(2, p, h);
                    check("R4 mem period", p, (mb != 0) ? br : 2 * br);
                    check("R4 mem high", h, (mb != 0) ? (br + 1) / 2 : br);

                    if (sr == 1) begin
                        sb_per = 2 * br;
                        sb_hi  = br;
                    end else begin
                        sb_per = sr * 2 * br;
                        sb_hi  = ((sr + 1) / 2) * 2 * br;
                    end
                    tag = (md < 2) ? "R5 sb" : "R6 sb";
                    measure(3, p, h);
                    check({tag, " period"}, p, sb_per);
                    check({tag, " high R7"}, h, sb_hi);
                end
            end
        end

        // R9: ratio change in mid-period completes the old period first
        bus_div_sel = 2'd0;
        legacy_mode = 1'b0;
        mem_cfg = 32'd0;
        sbus_cfg = 16'(7 << 13);
        wait_cycles(300);
        begin
            logic pv, cv, fall_seen;
            int hcnt, guard;
            @(negedge clk);
            pv = sb_clk;
            guard = 0;
            while (!(!pv && sb_clk) && guard < 1000) begin
                pv = sb_clk;
                @(negedge clk);
                guard++;
            end
            sbus_cfg = 16'(1 << 13);
            hcnt = 1;
            fall_seen = 1'b0;
            guard = 0;
            while (!fall_seen && guard < 1000) begin
                @(negedge clk);
                cv = sb_clk;
                if (cv) hcnt++;
                else fall_seen = 1'b1;
                guard++;
            end
            check("R9 old high kept", hcnt, 16);
        end
        measure(3, p, h);
        check("R9 new period", p, 8);
        check("R9 new high", h, 4);

        // R8: reset in the middle of operation drives outputs low
        @(negedge clk);
        rst = 1'b1;
        @(negedge clk);
        check("R8 mid-run bus", int'(bus_clk), 0);
        check("R8 mid-run sb", int'(sb_clk), 0);
        rst = 1'b0;
        wait_cycles(4);

        finish_run();
    end

endmodule